// File: doc/BRIEF.md
# Linked-List DMA Descriptor Engine

This block is one DMA channel. It walks a chain of descriptors kept in system memory and copies one buffer per descriptor. Each descriptor is five consecutive words at a base address, fetched in this order: source address (+0), destination address (+4), next-descriptor pointer (+8), control A (+12) and control B (+16). In control A, bits [15:0] give the buffer length in words and bit 31 is the DONE flag. All memory traffic uses a single word-wide master port. A request stays raised, with its address, write-enable and write data unchanged, until the memory returns an acknowledge.

Software builds the chain with DONE cleared in every descriptor. It presents the address of the first descriptor and pulses the enable. The channel loads all five words into its registers and copies the buffer word by word, advancing both addresses by one word each time. It then writes only the control A word back to the offset it was read from, with DONE set and the length field counted down to zero. After the write-back it raises the buffer interrupt and continues at once to the descriptor named by the loaded pointer, without waiting for the interrupt to be cleared. A zero pointer marks the last descriptor: after that write-back the channel also raises the chain interrupt and drops busy. Software should judge completion of a buffer from DONE in the descriptor in memory, not from the channel's registers.

Top module: `lldma_channel`

## Requirements
- R1: While reset is asserted and just after it is released, busy, mem_req, buf_irq and chain_irq are all 0.
- R2: An enable pulse while idle makes busy 1 one clock later. The channel then reads the five descriptor words at base+0, +4, +8, +12, +16 in that order, starting from first_desc_ptr. It makes no memory access that the chain does not call for.
- R3: For a length N > 0 in control A bits [15:0], the channel alternates N reads from source+4k and N writes of the read word to destination+4k, for k = 0..N-1. Memory just past the buffer is left unchanged.
- R4: After the copy, exactly one write goes to descriptor base+12. Its data has bit 31 set, bits [30:16] equal to the fetched control A, and bits [15:0] zero.
- R5: Each control A write-back sets buf_irq one clock after its acknowledge. The channel fetches the next descriptor while buf_irq is still set. An irq_clear pulse clears buf_irq and chain_irq, and a set in the same cycle takes priority over the clear.
- R6: When the loaded next pointer is zero, the channel sets chain_irq and drops busy in the clock after that descriptor's write-back acknowledge. A later enable starts a new chain.
- R7: An enable pulse while busy is ignored: the chain in progress keeps its access order and fetches nothing from the new pointer.
- R8: A length of zero performs no source or destination access, but the control A write-back still happens.
- R9: While mem_req is 1 and mem_ack is 0, mem_req stays 1 in the next cycle, and mem_addr, mem_we and mem_wdata hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| chan_en | input | 1 | One-cycle pulse that starts a chain when idle |
| first_desc_ptr | input | AW (32) | Base address of the first descriptor, sampled with chan_en |
| irq_clear | input | 1 | Pulse that clears both interrupt flags |
| buf_irq | output | 1 | Set after each descriptor write-back |
| chain_irq | output | 1 | Set after the write-back of the last descriptor |
| busy | output | 1 | Channel is working through a chain |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | 1 for a write request, 0 for a read |
| mem_addr | output | AW (32) | Byte address of the request |
| mem_wdata | output | DW (32) | Write data |
| mem_rdata | input | DW (32) | Read data, valid with mem_ack |
| mem_ack | input | 1 | Acknowledge, ends the current request |

## Verification
Each memory access ends on the clock edge that samples mem_ack high. The scoreboard therefore compares address, direction and write data at the falling edge inside the acknowledged cycle, and every access pops one expected entry, so both the order and the count of accesses are checked. Busy is sampled one falling edge after the enable edge. buf_irq, chain_irq and the drop of busy all become visible one cycle after the last write-back acknowledge, so those flags are read only after the bench has waited for busy to fall. The bench also records whether buf_irq was ever high while busy was still high. Memory contents, including sentinel words just past each buffer, are compared once the chain has finished.

// File: rtl/lldma_pkg.sv
package lldma_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH,
    ST_READ,
    ST_WRITE,
    ST_WBACK
  } dma_state_e;

  // word positions inside one descriptor, in fetch order
  localparam int DESC_WORDS = 5;
  localparam int IDX_SRC    = 0;
  localparam int IDX_DST    = 1;
  localparam int IDX_NEXT   = 2;
  localparam int IDX_CTLA   = 3;
  localparam int IDX_CTLB   = 4;
  localparam int IDX_W      = $clog2(DESC_WORDS);

  localparam int NUM_IRQ    = 2;
  localparam int IRQ_BUF    = 0;
  localparam int IRQ_CHAIN  = 1;

endpackage

// File: rtl/lldma_rst_sync.sv
module lldma_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_n_out = sync_q[STAGES-1];

endmodule

// File: rtl/lldma_fsm.sv
module lldma_fsm
  import lldma_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             chan_en,
  input  logic             mem_ack,
  input  logic             size_zero,
  input  logic             size_one,
  input  logic             next_null,
  output dma_state_e       state_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             load_first,
  output logic             fetch_ack,
  output logic             rd_ack,
  output logic             wr_ack,
  output logic             wb_ack,
  output logic             chain_end
);

  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(DESC_WORDS - 1);

  dma_state_e       state_q, state_d;
  logic [IDX_W-1:0] idx_q, idx_d;

  always_comb begin
    state_d    = state_q;
    idx_d      = idx_q;
    load_first = 1'b0;
    fetch_ack  = 1'b0;
    rd_ack     = 1'b0;
    wr_ack     = 1'b0;
    wb_ack     = 1'b0;
    chain_end  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (chan_en) begin
          load_first = 1'b1;
          idx_d      = '0;
          state_d    = ST_FETCH;
        end
      end
      ST_FETCH: begin
        if (mem_ack) begin
          fetch_ack = 1'b1;
          if (idx_q == IDX_LAST) begin
            idx_d   = '0;
            state_d = size_zero ? ST_WBACK : ST_READ;
          end else begin
            idx_d = idx_q + 1'b1;
          end
        end
      end
      ST_READ: begin
        if (mem_ack) begin
          rd_ack  = 1'b1;
          state_d = ST_WRITE;
        end
      end
      ST_WRITE: begin
        if (mem_ack) begin
          wr_ack  = 1'b1;
          state_d = size_one ? ST_WBACK : ST_READ;
        end
      end
      ST_WBACK: begin
        if (mem_ack) begin
          wb_ack = 1'b1;
          if (next_null) begin
            chain_end = 1'b1;
            state_d   = ST_IDLE;
          end else begin
            state_d = ST_FETCH;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
    end
  end

  assign state_o = state_q;
  assign idx_o   = idx_q;

endmodule

// File: rtl/lldma_regs.sv
module lldma_regs
  import lldma_pkg::*;
#(
  parameter int AW       = 32,
  parameter int DW       = 32,
  parameter int SW       = 16,
  parameter int DONE_BIT = 31
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_first,
  input  logic [AW-1:0]    first_ptr,
  input  logic             fetch_ack,
  input  logic [IDX_W-1:0] idx,
  input  logic [DW-1:0]    rdata,
  input  logic             rd_ack,
  input  logic             wr_ack,
  input  logic             wb_ack,
  output logic [AW-1:0]    src_o,
  output logic [AW-1:0]    dst_o,
  output logic [AW-1:0]    desc_o,
  output logic [DW-1:0]    ctlb_o,
  output logic [DW-1:0]    buf_o,
  output logic [DW-1:0]    wb_word_o,
  output logic             size_zero,
  output logic             size_one,
  output logic             next_null
);

  localparam int INC = DW / 8;

  logic [AW-1:0] src_q, src_d;
  logic [AW-1:0] dst_q, dst_d;
  logic [AW-1:0] next_q, next_d;
  logic [AW-1:0] desc_q, desc_d;
  logic [DW-1:0] ctla_q, ctla_d;
  logic [DW-1:0] ctlb_q, ctlb_d;
  logic [DW-1:0] buf_q, buf_d;
  logic          reg_en;

  assign reg_en = load_first | fetch_ack | rd_ack | wr_ack | wb_ack;

  always_comb begin
    src_d  = src_q;
    dst_d  = dst_q;
    next_d = next_q;
    desc_d = desc_q;
    ctla_d = ctla_q;
    ctlb_d = ctlb_q;
    buf_d  = buf_q;
    if (load_first) begin
      desc_d = first_ptr;
    end
    if (fetch_ack) begin
      case (int'(idx))
        IDX_SRC:  src_d  = AW'(rdata);
        IDX_DST:  dst_d  = AW'(rdata);
        IDX_NEXT: next_d = AW'(rdata);
        IDX_CTLA: ctla_d = rdata;
        IDX_CTLB: ctlb_d = rdata;
        default:  ;
      endcase
    end
    if (rd_ack) begin
      buf_d = rdata;
    end
    if (wr_ack) begin
      src_d            = src_q + AW'(INC);
      dst_d            = dst_q + AW'(INC);
      ctla_d[SW-1:0]   = ctla_q[SW-1:0] - 1'b1;
    end
    if (wb_ack) begin
      desc_d = next_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q  <= '0;
      dst_q  <= '0;
      next_q <= '0;
      desc_q <= '0;
      ctla_q <= '0;
      ctlb_q <= '0;
      buf_q  <= '0;
    end else if (reg_en) begin
      src_q  <= src_d;
      dst_q  <= dst_d;
      next_q <= next_d;
      desc_q <= desc_d;
      ctla_q <= ctla_d;
      ctlb_q <= ctlb_d;
      buf_q  <= buf_d;
    end
  end

  // length field has counted down to zero by the time of the write-back
  assign wb_word_o = ctla_q | (DW'(1) << DONE_BIT);
  assign size_zero = (ctla_q[SW-1:0] == '0);
  assign size_one  = (ctla_q[SW-1:0] == SW'(1));
  assign next_null = (next_q == '0);
  assign src_o     = src_q;
  assign dst_o     = dst_q;
  assign desc_o    = desc_q;
  assign ctlb_o    = ctlb_q;
  assign buf_o     = buf_q;

endmodule

// File: rtl/lldma_irq.sv
module lldma_irq #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set,
  input  logic         clear,
  output logic [N-1:0] flag
);

  for (genvar g = 0; g < N; g++) begin : g_flag
    logic flag_q, flag_d, flag_en;

    assign flag_en = set[g] | clear;

    always_comb begin
      flag_d = flag_q;
      if (set[g]) begin
        flag_d = 1'b1;
      end else if (clear) begin
        flag_d = 1'b0;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        flag_q <= 1'b0;
      end else if (flag_en) begin
        flag_q <= flag_d;
      end
    end

    assign flag[g] = flag_q;
  end

endmodule

// File: rtl/lldma_channel.sv
module lldma_channel
  import lldma_pkg::*;
#(
  parameter int AW       = 32,
  parameter int DW       = 32,
  parameter int SW       = 16,
  parameter int DONE_BIT = 31
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          chan_en,
  input  logic [AW-1:0] first_desc_ptr,
  input  logic          irq_clear,
  output logic          buf_irq,
  output logic          chain_irq,
  output logic          busy,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  input  logic          mem_ack
);

  localparam int WSH      = $clog2(DW / 8);
  localparam int CTLA_OFS = IDX_CTLA << WSH;

  logic             rst_int_n;
  dma_state_e       state;
  logic [IDX_W-1:0] idx;
  logic             load_first, fetch_ack, rd_ack, wr_ack, wb_ack, chain_end;
  logic             size_zero, size_one, next_null;
  logic [AW-1:0]    ch_src, ch_dst, ch_desc;
  logic [DW-1:0]    ch_ctrlb, ch_buf, ch_wb_word;
  logic [NUM_IRQ-1:0] irq_set, irq_flag;

  lldma_rst_sync #(.STAGES(2)) rst_sync_i (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_int_n)
  );

  lldma_fsm fsm_i (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .chan_en    (chan_en),
    .mem_ack    (mem_ack),
    .size_zero  (size_zero),
    .size_one   (size_one),
    .next_null  (next_null),
    .state_o    (state),
    .idx_o      (idx),
    .load_first (load_first),
    .fetch_ack  (fetch_ack),
    .rd_ack     (rd_ack),
    .wr_ack     (wr_ack),
    .wb_ack     (wb_ack),
    .chain_end  (chain_end)
  );

  lldma_regs #(
    .AW(AW), .DW(DW), .SW(SW), .DONE_BIT(DONE_BIT)
  ) regs_i (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .load_first (load_first),
    .first_ptr  (first_desc_ptr),
    .fetch_ack  (fetch_ack),
    .idx        (idx),
    .rdata      (mem_rdata),
    .rd_ack     (rd_ack),
    .wr_ack     (wr_ack),
    .wb_ack     (wb_ack),
    .src_o      (ch_src),
    .dst_o      (ch_dst),
    .desc_o     (ch_desc),
    .ctlb_o     (ch_ctrlb),
    .buf_o      (ch_buf),
    .wb_word_o  (ch_wb_word),
    .size_zero  (size_zero),
    .size_one   (size_one),
    .next_null  (next_null)
  );

  assign irq_set[IRQ_BUF]   = wb_ack;
  assign irq_set[IRQ_CHAIN] = chain_end;

  lldma_irq #(.N(NUM_IRQ)) irq_i (
    .clk   (clk),
    .rst_n (rst_int_n),
    .set   (irq_set),
    .clear (irq_clear),
    .flag  (irq_flag)
  );

  assign buf_irq   = irq_flag[IRQ_BUF];
  assign chain_irq = irq_flag[IRQ_CHAIN];
  assign busy      = (state != ST_IDLE);
  assign mem_req   = (state != ST_IDLE);
  assign mem_we    = (state == ST_WRITE) || (state == ST_WBACK);

  always_comb begin
    mem_addr  = '0;
    mem_wdata = '0;
    unique case (state)
      ST_FETCH: mem_addr = ch_desc + (AW'(idx) << WSH);
      ST_READ:  mem_addr = ch_src;
      ST_WRITE: begin
        mem_addr  = ch_dst;
        mem_wdata = ch_buf;
      end
      ST_WBACK: begin
        mem_addr  = ch_desc + AW'(CTLA_OFS);
        mem_wdata = ch_wb_word;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/lldma_channel_chk.sv
module lldma_channel_chk #(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          chan_en,
  input logic          busy,
  input logic          buf_irq,
  input logic          chain_irq,
  input logic          mem_req,
  input logic          mem_we,
  input logic          mem_ack,
  input logic [AW-1:0] mem_addr,
  input logic [DW-1:0] mem_wdata,
  input logic [DW-1:0] ch_ctrlb
);

  assert_req_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)
                               && $stable(mem_wdata)));

  assert_buf_irq_after_wb_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(buf_irq) |-> $past(mem_req && mem_we && mem_ack));

  assert_idle_with_chain_irq_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> chain_irq);

  assert_chain_with_buf_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(chain_irq) |-> buf_irq);

  assert_enable_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && chan_en && !mem_ack) |=> busy);

  assert_ctrlb_held_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |=> $stable(ch_ctrlb));

endmodule

bind lldma_channel lldma_channel_chk #(.AW(AW), .DW(DW)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .chan_en   (chan_en),
  .busy      (busy),
  .buf_irq   (buf_irq),
  .chain_irq (chain_irq),
  .mem_req   (mem_req),
  .mem_we    (mem_we),
  .mem_ack   (mem_ack),
  .mem_addr  (mem_addr),
  .mem_wdata (mem_wdata),
  .ch_ctrlb  (ch_ctrlb)
);

// File: tb/lldma_channel_tb_top.sv
module lldma_channel_tb_top;

  logic        clk;
  logic        rst_n;
  logic        chan_en;
  logic [31:0] first_desc_ptr;
  logic        irq_clear;
  logic        buf_irq, chain_irq, busy;
  logic        mem_req, mem_we, mem_ack;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;

  int n_chk  = 0;
  int n_fail = 0;
  bit saw_irq_busy;

  typedef struct {
    logic        we;
    logic [31:0] addr;
    logic [31:0] data;
    string       tag;
  } acc_t;

  acc_t exp_q[$];
  acc_t mon_e;

  // 200 MHz
  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  lldma_channel dut_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .chan_en        (chan_en),
    .first_desc_ptr (first_desc_ptr),
    .irq_clear      (irq_clear),
    .buf_irq        (buf_irq),
    .chain_irq      (chain_irq),
    .busy           (busy),
    .mem_req        (mem_req),
    .mem_we         (mem_we),
    .mem_addr       (mem_addr),
    .mem_wdata      (mem_wdata),
    .mem_rdata      (mem_rdata),
    .mem_ack        (mem_ack)
  );

  // memory model: one wait cycle per access
  logic [31:0] mem [0:255];
  logic        pl_en;
  logic [31:0] pl_addr, pl_data;
  logic        ack_q;
  logic [31:0] rd_q;

  always @(posedge clk) begin
    if (pl_en) begin
      mem[pl_addr[9:2]] <= pl_data;
    end else if (mem_req && !ack_q && mem_we) begin
      mem[mem_addr[9:2]] <= mem_wdata;
    end
    rd_q <= mem[mem_addr[9:2]];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ack_q <= 1'b0;
    else        ack_q <= mem_req && !ack_q;
  end

  assign mem_ack   = ack_q;
  assign mem_rdata = rd_q;

  function automatic logic [31:0] pat(input logic [31:0] a);
    return 32'hA500_0000 | a;
  endfunction

  task automatic chk(input bit ok, input string tag,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic push(input logic we, input logic [31:0] a,
                      input logic [31:0] d, input string t);
    acc_t e;
    e.we = we; e.addr = a; e.data = d; e.tag = t;
    exp_q.push_back(e);
  endtask

  // scoreboard driver: expected access stream of one descriptor
  task automatic expect_desc(input logic [31:0] base, input logic [31:0] src,
                             input logic [31:0] dst, input logic [31:0] ctla,
                             input string wbtag);
    for (int k = 0; k < 5; k++) push(1'b0, base + 32'(4*k), '0, "R2 descriptor fetch");
    for (int k = 0; k < int'(ctla[15:0]); k++) begin
      push(1'b0, src + 32'(4*k), '0, "R3 copy read");
      push(1'b1, dst + 32'(4*k), pat(src + 32'(4*k)), "R3 copy write");
    end
    push(1'b1, base + 32'd12, {1'b1, ctla[30:16], 16'h0000}, wbtag);
  endtask

  // monitor: compare each acknowledged access
  always @(negedge clk) begin
    if (rst_n && mem_req && mem_ack) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R2 unexpected access", mem_addr, 32'h0);
      end else begin
        mon_e = exp_q.pop_front();
        chk(mem_addr == mon_e.addr, mon_e.tag, mem_addr, mon_e.addr);
        chk(mem_we == mon_e.we, mon_e.tag, 32'(mem_we), 32'(mon_e.we));
        if (mon_e.we) chk(mem_wdata == mon_e.data, mon_e.tag, mem_wdata, mon_e.data);
      end
    end
  end

  task automatic poke(input logic [31:0] a, input logic [31:0] d);
    @(negedge clk);
    pl_en = 1'b1; pl_addr = a; pl_data = d;
  endtask

  task automatic poke_done();
    @(negedge clk);
    pl_en = 1'b0;
  endtask

  task automatic load_desc(input logic [31:0] base, input logic [31:0] src,
                           input logic [31:0] dst, input logic [31:0] nxt,
                           input logic [31:0] ctla, input logic [31:0] ctlb);
    poke(base, src); poke(base + 4, dst); poke(base + 8, nxt);
    poke(base + 12, ctla); poke(base + 16, ctlb);
  endtask

  task automatic pulse_en(input logic [31:0] ptr);
    @(negedge clk);
    chan_en = 1'b1; first_desc_ptr = ptr;
    @(negedge clk);
    chan_en = 1'b0;
  endtask

  task automatic wait_idle();
    int n = 0;
    while (busy && n < 6000) begin
      @(negedge clk);
      if (buf_irq && busy) saw_irq_busy = 1'b1;
      n++;
    end
    if (n >= 6000) chk(1'b0, "watchdog expired", 32'(n), 32'd6000);
  endtask

  initial begin
    rst_n = 1'b0; chan_en = 1'b0; first_desc_ptr = '0; irq_clear = 1'b0;
    pl_en = 1'b0; pl_addr = '0; pl_data = '0;
    saw_irq_busy = 1'b0;
    repeat (3) @(negedge clk);
    chk(busy == 1'b0,      "R1 busy in reset",      32'(busy), 0);
    chk(mem_req == 1'b0,   "R1 mem_req in reset",   32'(mem_req), 0);
    chk(buf_irq == 1'b0,   "R1 buf_irq in reset",   32'(buf_irq), 0);
    chk(chain_irq == 1'b0, "R1 chain_irq in reset", 32'(chain_irq), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(busy == 1'b0 && mem_req == 1'b0, "R1 idle after reset", 32'(busy), 0);

    // chain of three: lengths 3, 0, 1
    load_desc(32'h100, 32'h200, 32'h300, 32'h140, 32'h00AB_0003, 32'h1111_1111);
    load_desc(32'h140, 32'h240, 32'h340, 32'h180, 32'h0012_0000, 32'h2222_2222);
    load_desc(32'h180, 32'h260, 32'h360, 32'h000, 32'h0001_0001, 32'h3333_3333);
    for (int k = 0; k < 3; k++) poke(32'h200 + 32'(4*k), pat(32'h200 + 32'(4*k)));
    poke(32'h260, pat(32'h260));
    poke(32'h30C, 32'h5EE0_030C);
    poke(32'h340, 32'hDEAD_BEEF);
    poke(32'h364, 32'h5EE0_0364);
    poke(32'h3C0, 32'h0);
    poke_done();

    expect_desc(32'h100, 32'h200, 32'h300, 32'h00AB_0003, "R4 write-back");
    expect_desc(32'h140, 32'h240, 32'h340, 32'h0012_0000, "R8 zero-length write-back");
    expect_desc(32'h180, 32'h260, 32'h360, 32'h0001_0001, "R4 write-back last");

    pulse_en(32'h100);
    chk(busy == 1'b1, "R2 busy after enable", 32'(busy), 1);
    repeat (4) @(negedge clk);
    pulse_en(32'h3C0);   // R7: enable while busy, must be ignored
    wait_idle();
    @(negedge clk);

    chk(exp_q.size() == 0, "R2 R7 all expected accesses seen", 32'(exp_q.size()), 0);
    chk(busy == 1'b0,      "R6 busy dropped",   32'(busy), 0);
    chk(chain_irq == 1'b1, "R6 chain_irq set",  32'(chain_irq), 1);
    chk(buf_irq == 1'b1,   "R5 buf_irq set",    32'(buf_irq), 1);
    chk(saw_irq_busy,      "R5 continued with buf_irq pending", 32'(saw_irq_busy), 1);
    for (int k = 0; k < 3; k++)
      chk(mem[8'(32'hC0 + k)] == pat(32'h200 + 32'(4*k)), "R3 destination data",
          mem[8'(32'hC0 + k)], pat(32'h200 + 32'(4*k)));
    chk(mem[8'hC3] == 32'h5EE0_030C, "R3 word past buffer untouched", mem[8'hC3], 32'h5EE0_030C);
    chk(mem[8'hD0] == 32'hDEAD_BEEF, "R8 zero-length destination untouched", mem[8'hD0], 32'hDEAD_BEEF);
    chk(mem[8'hD9] == 32'h5EE0_0364, "R3 word past last buffer untouched", mem[8'hD9], 32'h5EE0_0364);
    chk(mem[8'h43] == 32'h80AB_0000, "R4 descriptor 0 DONE in memory", mem[8'h43], 32'h80AB_0000);
    chk(mem[8'h53] == 32'h8012_0000, "R8 descriptor 1 DONE in memory", mem[8'h53], 32'h8012_0000);
    chk(mem[8'h63] == 32'h8001_0000, "R4 descriptor 2 DONE in memory", mem[8'h63], 32'h8001_0000);

    @(negedge clk);
    irq_clear = 1'b1;
    @(negedge clk);
    irq_clear = 1'b0;
    chk(buf_irq == 1'b0,   "R5 buf_irq cleared",   32'(buf_irq), 0);
    chk(chain_irq == 1'b0, "R5 chain_irq cleared", 32'(chain_irq), 0);

    // second chain: single descriptor, length 2
    load_desc(32'h3C0, 32'h280, 32'h380, 32'h000, 32'h0005_0002, 32'h4444_4444);
    poke(32'h280, pat(32'h280));
    poke(32'h284, pat(32'h284));
    poke_done();
    expect_desc(32'h3C0, 32'h280, 32'h380, 32'h0005_0002, "R4 write-back second chain");
    pulse_en(32'h3C0);
    chk(busy == 1'b1, "R6 restart after idle", 32'(busy), 1);
    wait_idle();
    @(negedge clk);
    chk(exp_q.size() == 0, "R2 second chain accesses seen", 32'(exp_q.size()), 0);
    chk(chain_irq == 1'b1 && buf_irq == 1'b1, "R6 second chain done", 32'(chain_irq), 1);
    chk(mem[8'hE1] == pat(32'h284), "R3 second chain data", mem[8'hE1], pat(32'h284));
    chk(mem[8'hF3] == 32'h8005_0000, "R4 second chain DONE", mem[8'hF3], 32'h8005_0000);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule